// File: doc/BRIEF.md
# Energy-Gated Flit Hold Controller

This controller sits in front of one router output and decides how the flit at the head of an input buffer is paid for. It keeps a register holding the harvested energy stored at the tile. Energy arrives through a deposit port, and a deposit that would pass the register's maximum stops at that maximum. When a flit is presented, its cost is compared with the stored level. If the level covers the cost, the flit is released at once and the cost is deducted. If it does not, the buffer is switched to a low-voltage retention mode and a hold timer starts. The stored level is sampled again on every cycle of the wait, so energy that arrives during the hold can still release the flit on stored energy.

If the timer reaches the programmed limit first, the flit is released on external supply energy. That release is marked by a one-cycle flag and counted in a wrapping event counter. A limit of zero turns off holding, so a flit that lacks energy leaves at once on external supply. The controller has five states: ST_IDLE waits for a flit, ST_CHECK compares energy with cost, ST_HOLD waits in retention mode, ST_WAKE restores the normal supply for one cycle, and ST_SEND releases the flit. Its transitions are:

- accept: ST_IDLE to ST_CHECK
- pay-stored and pay-external-now: ST_CHECK to ST_SEND
- retain: ST_CHECK to ST_HOLD
- recharged and timeout: ST_HOLD to ST_WAKE
- resume: ST_WAKE to ST_SEND
- done: ST_SEND to ST_IDLE

Top module: `flit_energy_gate`

## Requirements
- R1: After reset the state is ST_IDLE, `fwd_go`, `fwd_ext` and `buf_low_v` are low, `energy_level` is 0 and `ext_count` is 0.
- R2: When `flit_valid` is first seen high and `energy_level` is at least `flit_cost`, `fwd_go` is high in the second cycle after that edge. In this case `fwd_ext` is low and `buf_low_v` never rises. This holds for a cost equal to the level.
- R3: A release on stored energy lowers `energy_level` by the latched cost on the clock edge that ends ST_SEND. Any deposit made on that same edge is added as well. The level never goes below zero.
- R4: A deposit (`charge_en` high for one cycle) adds `charge_amt` to the level, and the sum stops at 2^ENERGY_W-1.
- R5: When energy is short and the limit T is above 0, `buf_low_v` is high for exactly T cycles (ST_HOLD). It is low in the cycle before `fwd_go` (ST_WAKE), and `fwd_go` comes in cycle T+3.
- R6: A release after timeout raises `fwd_ext` together with `fwd_go` for one cycle and leaves `energy_level` unchanged.
- R7: With a limit of 0 and too little energy, the flit is released in cycle 2 with `fwd_ext` high and `buf_low_v` never high.
- R8: If a deposit during ST_HOLD brings the level up to the cost, the flit leaves through ST_WAKE and ST_SEND on stored energy. The release comes two cycles after the level change is visible, and no timeout is recorded.
- R9: `ext_count` rises by one, wrapping at 2^COUNT_W, for each external release and for nothing else.
- R10: `fwd_go` is a single-cycle pulse, and `fwd_ext` is high only while `fwd_go` is high.
- R11: `flit_cost` and `hold_limit` are latched on the accept edge. Changes to them during the hold have no effect on that flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| charge_en | input | 1 | Deposit harvested energy this cycle |
| charge_amt | input | ENERGY_W | Energy units deposited |
| hold_limit | input | TIMER_W | Hold timer limit T, in cycles (0 disables holding) |
| flit_valid | input | 1 | A flit waits at the buffer head |
| flit_cost | input | ENERGY_W | Energy units needed to send that flit |
| fwd_go | output | 1 | Flit released this cycle |
| fwd_ext | output | 1 | Release is paid from external supply |
| buf_low_v | output | 1 | Buffer in low-voltage retention mode |
| energy_level | output | ENERGY_W | Stored energy level |
| ext_count | output | COUNT_W | Count of external-energy releases |

## Verification
The bench builds the block with ENERGY_W=8 and COUNT_W=3, and keeps TIMER_W=8. An 8-bit reserve means two deposits reach the 255 ceiling, so the saturation check runs in a few cycles. A 3-bit event counter wraps after eight timeouts, which a short run of one-cycle holds can drive. Hold limits of 0, 1, 10 and 50 cover the bypass, the shortest hold, an ordinary timeout and an early wake well before expiry.

// File: rtl/efg_pkg.sv
package efg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_HOLD  = 3'd2,
        ST_WAKE  = 3'd3,
        ST_SEND  = 3'd4
    } efg_state_e;
endpackage

// File: rtl/efg_energy_reserve.sv
module efg_energy_reserve #(
    parameter int EW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [EW-1:0] add_amt,
    input  logic          take_en,
    input  logic [EW-1:0] take_amt,
    output logic [EW-1:0] level
);
    localparam logic [EW-1:0] LEVEL_MAX = '1;

    logic [EW-1:0] level_q;
    logic [EW-1:0] level_d;
    logic [EW:0]   after_take;
    logic [EW:0]   sum;

    always_comb begin
        after_take = {1'b0, level_q} - (take_en ? {1'b0, take_amt} : '0);
        sum        = after_take + (add_en ? {1'b0, add_amt} : '0);
        level_d    = sum[EW] ? LEVEL_MAX : sum[EW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign level = level_q;

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |-> (take_amt <= level_q));

    // R3
    stored_debit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_en && !add_en) |=> (level_q == $past(level_q) - $past(take_amt)));

    // R4
    deposit_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !take_en) |=> (level_q >= $past(level_q)));
endmodule

// File: rtl/efg_hold_timer.sv
module efg_hold_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    assign expire = tick && (({1'b0, cnt_q} + {{TW{1'b0}}, 1'b1}) == {1'b0, limit});

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q < limit));
endmodule

// File: rtl/efg_event_counter.sv
module efg_event_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   count_q <= '0;
        else if (inc) count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (count_q == $past(count_q) + 1'b1));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count_q));
endmodule

// File: rtl/efg_ctrl.sv
module efg_ctrl
    import efg_pkg::*;
#(
    parameter int EW = 12,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flit_valid,
    input  logic [EW-1:0] flit_cost,
    input  logic [TW-1:0] hold_limit,
    input  logic [EW-1:0] energy_level,
    input  logic          timer_expire,
    output logic          take_en,
    output logic [EW-1:0] take_amt,
    output logic          timer_clear,
    output logic          timer_tick,
    output logic [TW-1:0] limit_q,
    output logic          fwd_go,
    output logic          fwd_ext,
    output logic          low_v
);
    efg_state_e    state_q, state_d;
    logic [EW-1:0] cost_q;
    logic          ext_q, ext_d;
    logic          enough;

    assign enough = (energy_level >= cost_q);

    always_comb begin
        state_d = state_q;
        ext_d   = ext_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flit_valid) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (enough) begin
                    state_d = ST_SEND;
                    ext_d   = 1'b0;
                end else if (limit_q == '0) begin
                    state_d = ST_SEND;
                    ext_d   = 1'b1;
                end else begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (enough) begin
                    state_d = ST_WAKE;
                    ext_d   = 1'b0;
                end else if (timer_expire) begin
                    state_d = ST_WAKE;
                    ext_d   = 1'b1;
                end
            end
            ST_WAKE: state_d = ST_SEND;
            ST_SEND: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cost_q  <= '0;
            limit_q <= '0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ext_q   <= ext_d;
            if (state_q == ST_IDLE && flit_valid) begin
                cost_q  <= flit_cost;
                limit_q <= hold_limit;
            end
        end
    end

    always_comb begin
        low_v       = (state_q == ST_HOLD);
        fwd_go      = (state_q == ST_SEND);
        fwd_ext     = (state_q == ST_SEND) && ext_q;
        take_en     = (state_q == ST_SEND) && !ext_q;
        take_amt    = cost_q;
        timer_clear = (state_q != ST_HOLD);
        timer_tick  = (state_q == ST_HOLD) && !enough;
    end

    // R10
    ext_with_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_ext |-> fwd_go);

    // R10
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_go |=> !fwd_go);

    // R5
    wake_before_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_SEND));

    // R7
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && limit_q == '0) |=> !low_v);

    // R11
    cost_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(cost_q));
endmodule

// File: rtl/flit_energy_gate.sv
module flit_energy_gate #(
    parameter int ENERGY_W = 12,
    parameter int TIMER_W  = 8,
    parameter int COUNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                charge_en,
    input  logic [ENERGY_W-1:0] charge_amt,
    input  logic [TIMER_W-1:0]  hold_limit,
    input  logic                flit_valid,
    input  logic [ENERGY_W-1:0] flit_cost,
    output logic                fwd_go,
    output logic                fwd_ext,
    output logic                buf_low_v,
    output logic [ENERGY_W-1:0] energy_level,
    output logic [COUNT_W-1:0]  ext_count
);
    logic                take_en;
    logic [ENERGY_W-1:0] take_amt;
    logic                timer_clear;
    logic                timer_tick;
    logic                timer_expire;
    logic [TIMER_W-1:0]  limit_q;

    efg_ctrl #(.EW(ENERGY_W), .TW(TIMER_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flit_valid   (flit_valid),
        .flit_cost    (flit_cost),
        .hold_limit   (hold_limit),
        .energy_level (energy_level),
        .timer_expire (timer_expire),
        .take_en      (take_en),
        .take_amt     (take_amt),
        .timer_clear  (timer_clear),
        .timer_tick   (timer_tick),
        .limit_q      (limit_q),
        .fwd_go       (fwd_go),
        .fwd_ext      (fwd_ext),
        .low_v        (buf_low_v)
    );

    efg_energy_reserve #(.EW(ENERGY_W)) reserve_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (charge_en),
        .add_amt  (charge_amt),
        .take_en  (take_en),
        .take_amt (take_amt),
        .level    (energy_level)
    );

    efg_hold_timer #(.TW(TIMER_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (timer_clear),
        .tick   (timer_tick),
        .limit  (limit_q),
        .expire (timer_expire)
    );

    efg_event_counter #(.CW(COUNT_W)) counter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fwd_ext),
        .count (ext_count)
    );

    // R5
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_low_v |-> !fwd_go);
endmodule

// File: tb/flit_energy_gate_tb_top.sv
module flit_energy_gate_tb_top;
    localparam int EW = 8;
    localparam int TW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          charge_en;
    logic [EW-1:0] charge_amt;
    logic [TW-1:0] hold_limit;
    logic          flit_valid;
    logic [EW-1:0] flit_cost;
    logic          fwd_go, fwd_ext, buf_low_v;
    logic [EW-1:0] energy_level;
    logic [CW-1:0] ext_count;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    flit_energy_gate #(.ENERGY_W(EW), .TIMER_W(TW), .COUNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .charge_en(charge_en), .charge_amt(charge_amt),
        .hold_limit(hold_limit), .flit_valid(flit_valid), .flit_cost(flit_cost),
        .fwd_go(fwd_go), .fwd_ext(fwd_ext), .buf_low_v(buf_low_v),
        .energy_level(energy_level), .ext_count(ext_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; charge_en = 1'b0; charge_amt = '0; hold_limit = '0;
        flit_valid = 1'b0; flit_cost = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        @(negedge clk);
    endtask

    task automatic charge(input int amt);
        charge_en = 1'b1; charge_amt = EW'(amt);
        @(negedge clk);
        charge_en = 1'b0;
    endtask

    // Presents one flit and measures the cycle of fwd_go, hold cycles and flags.
    task automatic run_flit(input int cost, input int lim, input int chg_at, input int chg_amt,
                            output int lat, output int lowc, output bit ext, output bit low_before_go,
                            output bit pulse_ok);
        bit prev_low = 1'b0;
        lat = 0; lowc = 0; ext = 1'b0; low_before_go = 1'b0; pulse_ok = 1'b1;
        flit_valid = 1'b1; flit_cost = EW'(cost); hold_limit = TW'(lim);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lat++;
            charge_en = 1'b0;
            flit_cost = EW'(cost + 1);       // R11: later changes must be ignored
            hold_limit = TW'(lim + 3);
            if (fwd_ext && !fwd_go) pulse_ok = 1'b0;
            if (buf_low_v) lowc++;
            if (fwd_go) begin
                ext = fwd_ext;
                low_before_go = prev_low;
                break;
            end
            prev_low = buf_low_v;
            if (lat == chg_at) begin
                charge_en = 1'b1; charge_amt = EW'(chg_amt);
            end
        end
        flit_valid = 1'b0;
        @(negedge clk);
        if (fwd_go || fwd_ext) pulse_ok = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(!fwd_go && !fwd_ext && !buf_low_v, "R1 outputs idle", fwd_go, 0);
        check(energy_level == 0, "R1 energy", energy_level, 0);
        check(ext_count == 0, "R1 count", ext_count, 0);
    endtask

    task automatic t_stored();
        int lat, lowc; bit ext, lb, pk;
        do_reset();
        charge(100);
        run_flit(30, 10, 0, 0, lat, lowc, ext, lb, pk);
        check(lat == 2, "R2 latency", lat, 2);
        check(!ext && lowc == 0, "R2 no ext/no low", lowc, 0);
        check(energy_level == 70, "R3 debit", energy_level, 70);
        check(pk, "R10 pulse", pk, 1);
        run_flit(70, 10, 0, 0, lat, lowc, ext, lb, pk);
        check(lat == 2 && !ext, "R2 equal cost", lat, 2);
        check(energy_level == 0, "R3 debit to zero", energy_level, 0);
        check(ext_count == 0, "R9 no count on stored", ext_count, 0);
    endtask

    task automatic t_timeout(input int lim);
        int lat, lowc; bit ext, lb, pk;
        do_reset();
        charge(4);
        run_flit(5, lim, 0, 0, lat, lowc, ext, lb, pk);
        exp_cnt++;
        check(lat == lim + 3, "R5 latency", lat, lim + 3);
        check(lowc == lim, "R5 low-voltage cycles", lowc, lim);
        check(!lb, "R5 wake before send", lb, 0);
        check(ext, "R6 ext flag", ext, 1);
        check(pk, "R10 pulse", pk, 1);
        check(energy_level == 4, "R6 energy kept", energy_level, 4);
        check(ext_count == CW'(exp_cnt), "R9 count", ext_count, exp_cnt);
    endtask

    task automatic t_zero_limit();
        int lat, lowc; bit ext, lb, pk;
        do_reset();
        run_flit(9, 0, 0, 0, lat, lowc, ext, lb, pk);
        check(lat == 2, "R7 latency", lat, 2);
        check(ext && lowc == 0, "R7 ext, no hold", lowc, 0);
        check(ext_count == 1, "R9 count", ext_count, 1);
    endtask

    task automatic t_early_wake();
        int lat, lowc; bit ext, lb, pk;
        do_reset();
        charge(10);
        run_flit(40, 50, 5, 50, lat, lowc, ext, lb, pk);
        check(lat == 8, "R8 latency", lat, 8);
        check(lowc == 5, "R8 hold cycles", lowc, 5);
        check(!ext && !lb, "R8 stored wake", ext, 0);
        check(energy_level == 20, "R8 debit", energy_level, 20);
        check(ext_count == 0, "R8 no count", ext_count, 0);
    endtask

    task automatic t_saturate();
        do_reset();
        charge(200);
        check(energy_level == 200, "R4 add", energy_level, 200);
        charge(200);
        check(energy_level == 255, "R4 saturate", energy_level, 255);
    endtask

    task automatic t_wrap();
        int lat, lowc; bit ext, lb, pk;
        do_reset();
        for (int k = 0; k < 9; k++) begin
            run_flit(1, 1, 0, 0, lat, lowc, ext, lb, pk);
            check(lat == 4 && ext, "R5 T=1 timeout", lat, 4);
        end
        check(ext_count == 1, "R9 wrap", ext_count, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_stored();
        t_timeout(10);
        t_timeout(1);
        t_zero_limit();
        t_early_wake();
        t_saturate();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule